// File: doc/BRIEF.md
# Dual-Width Compare Timer

This block is an up-counter that advances by one on each cycle where its timer clock enable is high. A control bit chooses between two widths. In narrow mode only the low counter byte counts, and two independent 8-bit compare channels watch it. In wide mode the full 16-bit counter counts, and the two compare bytes join into one 16-bit compare value. A second control bit picks free-running counting or clear-on-compare counting, in which compare value A (or the joined 16-bit value) acts as the top of the count.

Three event flags record overflow, compare A and compare B. Software clears a flag by writing a one to its bit, and an interrupt acknowledge line per flag also clears it. Each flag drives its own interrupt request, which is gated by a per-flag enable and a global enable. All registers are reached through a simple 8-bit register port with a combinational read path. A write to either counter byte masks compare matching for the one timer tick that follows it.

Top module: `dwc_timer`

## Requirements
- R1: After reset, every register (control, both counter bytes, both compare bytes, enables, flags) reads zero and all three interrupt requests are low.
- R2: The counter changes only on a tick or a counter write. In narrow mode (control bit 0 = 0) a tick adds one to the low byte, which wraps from 0xFF to 0x00 and leaves the high byte unchanged.
- R3: In wide mode (control bit 0 = 1) a tick adds one to the full 16-bit value, carrying from the low byte into the high byte.
- R4: In narrow mode, a tick taken while the low byte equals compare A sets flag bit 1, and a tick taken while it equals compare B sets flag bit 2.
- R5: In wide mode, a tick taken while the counter equals {compare B, compare A} (B is the high byte) sets flag bit 1 only. Flag bit 2 is never set in wide mode.
- R6: A tick taken while the counter holds the all-ones value of the active width (0xFF in the low byte, or 0xFFFF) sets flag bit 0. In wide mode the low byte wrapping alone does not set it.
- R7: In clear-on-compare mode (control bit 1 = 1), a tick taken while the counter is at the compare value returns the counter to zero (the low byte only in narrow mode) instead of incrementing it.
- R8: A write to either counter byte suppresses compare matching (both flags and the clear-on-compare reset) on the first tick after the write. Later ticks match normally.
- R9: Writing one to a flag bit at address 6 clears it. If a hardware set of the same flag happens in the same cycle, the flag is set.
- R10: A one on an acknowledge input bit (bit 0 overflow, bit 1 compare A, bit 2 compare B) clears the matching flag.
- R11: Interrupt request bit n (same bit order as the flags) is high exactly when flag n, enable bit n (address 5) and the global enable are all high.
- R12: Register addresses: 0 control, 1 counter low byte, 2 counter high byte, 3 compare A, 4 compare B, 5 interrupt enables, 6 flags. Unused control, enable and flag bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timer clock enable; the counter advances on cycles where it is high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 3 | Per-flag acknowledge that clears the flag |
| irq | output | 3 | Per-flag interrupt request |

## Verification
On every cycle, the assertions check the following: the counter holds its value when there is no tick and no write; the high byte stays still in narrow mode; a wide-mode overflow lands on zero; flag B never rises in wide mode; no compare flag rises on the tick right after a counter write; and flags follow the rule that a set wins over a clear. The bench scenarios alone can show exact counts. These include the tick on which each compare fires, the wrap position of clear-on-compare in both widths, the length of the masked window after a counter write, and the combined interrupt gating as seen on the ports.

// File: rtl/dwc_timer_pkg.sv
// Package: shared register addresses and flag positions for the dual-width
// compare timer. Assumes a byte-wide register port with 3 address bits.
package dwc_timer_pkg;

    localparam int unsigned ADDR_W = 3;
    localparam int unsigned NFLAGS = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 3'd0,
        RA_CNT_LO = 3'd1,
        RA_CNT_HI = 3'd2,
        RA_CMP_A  = 3'd3,
        RA_CMP_B  = 3'd4,
        RA_IEN    = 3'd5,
        RA_FLAGS  = 3'd6
    } reg_addr_e;

    // flag / enable / request bit positions
    localparam int unsigned FL_OVF  = 0;
    localparam int unsigned FL_CMPA = 1;
    localparam int unsigned FL_CMPB = 2;

    // control bit positions
    localparam int unsigned CT_WIDE = 0;
    localparam int unsigned CT_CTC  = 1;

endpackage

// File: rtl/dwc_timer_regs.sv
// Module: control, compare and interrupt-enable registers.
// Assumes writes are decoded by address here; reads are muxed in the top.
module dwc_timer_regs
    import dwc_timer_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              wide,
    output logic              ctc,
    output logic [BYTE_W-1:0] cmp_a,
    output logic [BYTE_W-1:0] cmp_b,
    output logic [NFLAGS-1:0] ien
);

    // store software-written configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide  <= 1'b0;
            ctc   <= 1'b0;
            cmp_a <= '0;
            cmp_b <= '0;
            ien   <= '0;
        end else if (wr_en) begin
            case (addr)
                RA_CTRL: begin
                    wide <= wdata[CT_WIDE];
                    ctc  <= wdata[CT_CTC];
                end
                RA_CMP_A: cmp_a <= wdata;
                RA_CMP_B: cmp_b <= wdata;
                RA_IEN:   ien   <= wdata[NFLAGS-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dwc_timer_count.sv
// Module: the counter, compare logic and event generation.
// Assumes the counter is two bytes; in narrow mode only the low byte counts.
// A counter write takes priority over a tick in the same cycle and masks
// compare matching on the next tick.
module dwc_timer_count
    import dwc_timer_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                wide,
    input  logic                ctc,
    input  logic [BYTE_W-1:0]   cmp_a,
    input  logic [BYTE_W-1:0]   cmp_b,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [2*BYTE_W-1:0] cnt,
    output logic [NFLAGS-1:0]   evt
);

    localparam int unsigned CNT_W = 2 * BYTE_W;

    logic              block_q;
    logic              cnt_wr;
    logic [CNT_W-1:0]  cnt_act;
    logic [CNT_W-1:0]  top;
    logic              hit_a, hit_b, live, at_max;
    logic [CNT_W-1:0]  cnt_nxt;

    assign cnt_wr = wr_lo | wr_hi;

    // compare and event decode for the current counter value
    always_comb begin
        cnt_act = wide ? cnt : {{BYTE_W{1'b0}}, cnt[BYTE_W-1:0]};
        top     = wide ? {cmp_b, cmp_a} : {{BYTE_W{1'b0}}, cmp_a};
        hit_a   = (cnt_act == top);
        hit_b   = !wide && (cnt[BYTE_W-1:0] == cmp_b);
        live    = tick && !cnt_wr && !block_q;
        at_max  = wide ? (&cnt) : (&cnt[BYTE_W-1:0]);
        evt           = '0;
        evt[FL_OVF]   = tick && !cnt_wr && at_max;
        evt[FL_CMPA]  = live && hit_a;
        evt[FL_CMPB]  = live && hit_b;
    end

    // next counter value: write, clear-on-compare, or increment
    always_comb begin
        cnt_nxt = cnt;
        if (cnt_wr) begin
            if (wr_lo) cnt_nxt[BYTE_W-1:0]     = wdata;
            if (wr_hi) cnt_nxt[CNT_W-1:BYTE_W] = wdata;
        end else if (tick) begin
            if (ctc && evt[FL_CMPA]) begin
                if (wide) cnt_nxt = '0;
                else      cnt_nxt[BYTE_W-1:0] = '0;
            end else if (wide) begin
                cnt_nxt = cnt + 1'b1;
            end else begin
                cnt_nxt[BYTE_W-1:0] = cnt[BYTE_W-1:0] + 1'b1;
            end
        end
    end

    // counter register
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end

    // one-tick compare mask armed by a counter write
    always_ff @(posedge clk) begin
        if (!rst_n)      block_q <= 1'b0;
        else if (cnt_wr) block_q <= 1'b1;
        else if (tick)   block_q <= 1'b0;
    end

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(cnt)); // R2
    AST_NARROW_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide && !wr_hi) |=> $stable(cnt[CNT_W-1:BYTE_W])); // R2
    AST_WIDE_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && wide && (&cnt)) |=> (cnt == '0)); // R6

endmodule

// File: rtl/dwc_timer_flags.sv
// Module: event flags with write-one-to-clear and acknowledge clearing,
// plus the gated interrupt requests. Assumes a set beats a clear.
module dwc_timer_flags #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] w1c,
    input  logic [N-1:0] ack,
    input  logic [N-1:0] en,
    input  logic         gie,
    output logic [N-1:0] flags,
    output logic [N-1:0] irq
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        // one flag: set has priority over either clear source
        always_ff @(posedge clk) begin
            if (!rst_n)       flags[i] <= 1'b0;
            else if (set[i])  flags[i] <= 1'b1;
            else if (w1c[i] || ack[i]) flags[i] <= 1'b0;
        end

        assign irq[i] = flags[i] & en[i] & gie;

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flags[i]); // R9
        AST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
            (!set[i] && (w1c[i] || ack[i])) |=> !flags[i]); // R10
        AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!set[i] && !w1c[i] && !ack[i]) |=> $stable(flags[i])); // R9
    end

endmodule

// File: rtl/dwc_timer.sv
// Module: top of the dual-width compare timer. Decodes the register port,
// muxes read data and ties the register, counter and flag units together.
// Assumes a synchronous active-low reset and combinational reads.
module dwc_timer
    import dwc_timer_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              gie,
    input  logic [2:0]        irq_ack,
    output logic [2:0]        irq
);

    localparam int unsigned CNT_W = 2 * BYTE_W;

    logic              wide, ctc;
    logic [BYTE_W-1:0] cmp_a, cmp_b;
    logic [NFLAGS-1:0] ien, evt, flags, w1c;
    logic [CNT_W-1:0]  cnt;
    logic              wr_lo, wr_hi;

    // write strobes for counter bytes and flag clearing
    always_comb begin
        wr_lo = reg_wr && (reg_addr == RA_CNT_LO);
        wr_hi = reg_wr && (reg_addr == RA_CNT_HI);
        w1c   = (reg_wr && (reg_addr == RA_FLAGS)) ? reg_wdata[NFLAGS-1:0] : '0;
    end

    dwc_timer_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .wide  (wide),
        .ctc   (ctc),
        .cmp_a (cmp_a),
        .cmp_b (cmp_b),
        .ien   (ien)
    );

    dwc_timer_count #(.BYTE_W(BYTE_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .wide  (wide),
        .ctc   (ctc),
        .cmp_a (cmp_a),
        .cmp_b (cmp_b),
        .wr_lo (wr_lo),
        .wr_hi (wr_hi),
        .wdata (reg_wdata),
        .cnt   (cnt),
        .evt   (evt)
    );

    dwc_timer_flags #(.N(NFLAGS)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (evt),
        .w1c   (w1c),
        .ack   (irq_ack),
        .en    (ien),
        .gie   (gie),
        .flags (flags),
        .irq   (irq)
    );

    // read data mux; unused bits read zero
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata[CT_WIDE] = wide;
                reg_rdata[CT_CTC]  = ctc;
            end
            RA_CNT_LO: reg_rdata = cnt[BYTE_W-1:0];
            RA_CNT_HI: reg_rdata = cnt[CNT_W-1:BYTE_W];
            RA_CMP_A:  reg_rdata = cmp_a;
            RA_CMP_B:  reg_rdata = cmp_b;
            RA_IEN:    reg_rdata[NFLAGS-1:0] = ien;
            RA_FLAGS:  reg_rdata[NFLAGS-1:0] = flags;
            default:   reg_rdata = '0;
        endcase
    end

    AST_WIDE_NO_FLAG_B: assert property (@(posedge clk) disable iff (!rst_n)
        wide |=> !$rose(flags[FL_CMPB])); // R5
    AST_MASK_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_lo || wr_hi) && tick && !(wr_lo || wr_hi))
        |=> (!$rose(flags[FL_CMPA]) && !$rose(flags[FL_CMPB]))); // R8

endmodule

// File: tb/test_dwc_timer.sv
`timescale 1ns/1ps
module test_dwc_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       gie = 1'b0;
    logic [2:0] irq_ack = 3'd0;
    logic [2:0] irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    typedef struct {
        bit         is_irq;
        logic [2:0] addr;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];

    always #10 clk = ~clk;

    dwc_timer i_dwc_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .gie       (gie),
        .irq_ack   (irq_ack),
        .irq       (irq)
    );

    // monitor: pop one expected item per falling edge and compare
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? {5'd0, irq} : reg_rdata;
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s addr=%0d actual=0x%02h expected=0x%02h",
                             it.tag, it.addr, act, it.exp);
                end
            end
        end
    end

    task automatic chk(input bit is_irq, input logic [2:0] a,
                       input logic [7:0] e, input string tag);
        item_t it;
        it.is_irq = is_irq; it.addr = a; it.exp = e; it.tag = tag;
        reg_addr = a;
        sb_q.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(posedge clk);
        #1;
        tick = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // watchdog
    initial begin
        #2000000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 7; a++) chk(0, 3'(a), 8'h00, "R1 reset reg");
        chk(1, 3'd0, 8'h00, "R1 reset irq");

        // R4 narrow compares
        wr(3, 8'd3); wr(4, 8'd5);
        ticks(3);
        chk(0, 1, 8'd3, "R2 narrow count");
        chk(0, 6, 8'h00, "R4 no early match");
        ticks(1);
        chk(0, 6, 8'h02, "R4 compare A");
        ticks(2);
        chk(0, 6, 8'h06, "R4 compare B");

        // R11 gating
        wr(5, 8'h02);
        chk(1, 0, 8'h00, "R11 global enable low");
        gie = 1'b1;
        chk(1, 0, 8'h02, "R11 request A");

        // R10 acknowledge, R9 write-one clear
        irq_ack = 3'b010; @(posedge clk); #1; irq_ack = 3'b000;
        chk(0, 6, 8'h04, "R10 ack clears A");
        wr(6, 8'h04);
        chk(0, 6, 8'h00, "R9 w1c clears B");

        // R6 narrow overflow, R2 high byte untouched
        wr(2, 8'h12); wr(1, 8'hFE);
        ticks(2);
        chk(0, 1, 8'h00, "R2 low byte wrap");
        chk(0, 2, 8'h12, "R2 high byte held");
        chk(0, 6, 8'h01, "R6 narrow overflow");
        wr(6, 8'h07);

        // R9 set beats clear in the same cycle
        ticks(3);
        tick = 1'b1; reg_addr = 3'd6; reg_wdata = 8'h02; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0; tick = 1'b0;
        chk(0, 6, 8'h02, "R9 set wins");
        chk(1, 0, 8'h02, "R11 request after set");
        wr(6, 8'h02);
        chk(0, 6, 8'h00, "R9 plain clear");

        // R8 masked tick after counter write
        wr(1, 8'd3);
        ticks(1);
        chk(0, 1, 8'd4, "R8 count after masked tick");
        chk(0, 6, 8'h00, "R8 match masked");
        wr(1, 8'd2);
        ticks(2);
        chk(0, 6, 8'h02, "R8 mask lasts one tick");
        wr(6, 8'h07);

        // R7 narrow clear-on-compare
        wr(0, 8'h02); wr(1, 8'd0);
        ticks(4);
        chk(0, 1, 8'd0, "R7 narrow clear to zero");
        chk(0, 6, 8'h02, "R7 flag at top");
        ticks(2);
        chk(0, 1, 8'd2, "R7 restart count");
        chk(0, 2, 8'h12, "R7 high byte held");
        wr(6, 8'h07);

        // R3, R5 wide mode
        wr(0, 8'h01); wr(3, 8'h02); wr(4, 8'h01);
        wr(2, 8'h00); wr(1, 8'hFF);
        ticks(1);
        chk(0, 2, 8'h01, "R3 carry into high");
        chk(0, 1, 8'h00, "R3 low after carry");
        chk(0, 6, 8'h00, "R6 no overflow on low wrap");
        ticks(3);
        chk(0, 6, 8'h02, "R5 wide match A only");
        chk(0, 1, 8'h03, "R3 wide count");
        wr(6, 8'h07);

        // R6 wide overflow, R11, R10
        wr(2, 8'hFF); wr(1, 8'hFF);
        ticks(1);
        chk(0, 2, 8'h00, "R6 wide wrap");
        chk(0, 6, 8'h01, "R6 wide overflow");
        wr(5, 8'h07);
        chk(1, 0, 8'h01, "R11 overflow request");
        irq_ack = 3'b001; @(posedge clk); #1; irq_ack = 3'b000;
        chk(0, 6, 8'h00, "R10 ack clears overflow");

        // R7 wide clear-on-compare
        wr(0, 8'h03); wr(2, 8'h01); wr(1, 8'h01);
        ticks(2);
        chk(0, 1, 8'h00, "R7 wide clear low");
        chk(0, 2, 8'h00, "R7 wide clear high");
        chk(0, 6, 8'h02, "R7 wide flag");
        chk(0, 0, 8'h03, "R12 control readback");

        while (sb_q.size() > 0) @(posedge clk);
        @(posedge clk);
        finished = 1;
        summary();
        $finish;
    end

endmodule